// File: doc/BRIEF.md
# Counting Semaphore Cell with Blocking Waiters

This block is a single communication cell that behaves as a counting semaphore with a 16-bit count. Software reaches it through a view code that goes with each access. A read through one of the two semaphore views is a "take" operation. It returns the count as it stood before the access. If that count was above zero, the read also lowers it by one. If the count was zero, the waiting view raises a stall and records the requester in a mask of blocked requesters. The polling view instead returns zero and changes nothing. A write through either semaphore view is a "give" operation. Its data is ignored, the count rises by one up to 0xFFFF, and every recorded requester is released at once through a one-cycle wake pulse that carries the mask.

A level state machine tracks the count. It has three states: S_ZERO, S_COUNTING and S_SATURATED. Transitions:
- give from S_ZERO: S_ZERO to S_COUNTING.
- take to zero: S_COUNTING to S_ZERO, when a take lowers the count to 0.
- give to the top: S_COUNTING to S_SATURATED, when a give raises the count to 0xFFFF.
- take from the top: S_SATURATED to S_COUNTING.

Every other access keeps the current state. The state decides whether a take may lower the count and whether a give may raise it. Responses (read data, read valid and stall) and the wake pulse are registered, so they appear in the cycle after the access. The raw view reads the count without side effects. Retrying a stalled access is left to the requester.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the blocked mask is empty, and rd_valid, stall and wake_pulse are 0.
- R2: A read with view 4 or 5 returns the count as it stood before the access on rd_data, with rd_valid high, in the cycle after the access. If that count was above zero, it is lowered by one.
- R3: A read with view 4 when the count is 0 gives stall=1 and rd_data=0 in the next cycle. It sets bit req_id of the blocked mask and leaves the count at 0.
- R4: A read with view 5 when the count is 0 returns 0 with stall=0 and does not record the requester.
- R5: A write with view 4 or 5 ignores wr_data and raises the count by one, but never above 0xFFFF.
- R6: In the cycle after a write with view 4 or 5, if the blocked mask was not empty, wake_pulse is high for one cycle and wake_mask equals that mask; the mask is then empty.
- R7: A read with view 0 returns the count without changing it, and a write with view 0 has no effect.
- R8: Views 1, 2, 3 and 6 to 15 read as 0 with no stall, and writes through them have no effect.
- R9: A read and a write with a semaphore view in the same cycle act as the take on the old count followed by the give. A stall bit set in that cycle is kept in the new mask and is not part of that cycle's wake mask. At the top count, the count stays at 0xFFFF.
- R10: wake_pulse never rises while the blocked mask is empty, and wake_mask is nonzero whenever wake_pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_view | input | 4 | View code: 0 raw, 4 waiting semaphore, 5 polling semaphore, others inert |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data (ignored by the semaphore) |
| req_id | input | ID_W | Identity of the requester |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read response valid, one cycle after rd_en |
| stall | output | 1 | The last read must wait |
| wake_pulse | output | 1 | One-cycle release of blocked requesters |
| wake_mask | output | 2**ID_W | Requesters released by wake_pulse |

## Verification
Takes are tried at a positive count, at zero through each of the two views, and at the saturated top. These cases separate the pre-decrement return, the stall and the silent poll, and the ceiling. Blocking by two distinct requesters followed by two gives shows that the mask accumulates, is sent whole once and is then cleared. Gives with differing data show that the data has no part in the count. A take and a give in the same cycle show whether a fresh stall bit survives the wake that clears the old mask. Accesses through the raw view and the inert views, with a nonzero count, show that nothing outside the semaphore views moves the state.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    typedef enum logic [3:0] {
        VW_RAW      = 4'd0,
        VW_TAG      = 4'd1,
        VW_QSYNC    = 4'd2,
        VW_QTRY     = 4'd3,
        VW_SEM_WAIT = 4'd4,
        VW_SEM_POLL = 4'd5
    } view_e;

    typedef enum logic [1:0] {
        S_ZERO      = 2'd0,
        S_COUNTING  = 2'd1,
        S_SATURATED = 2'd2
    } lvl_e;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
    import sem_cell_pkg::*;
(
    input  logic [3:0] acc_view,
    output logic       is_sem,
    output logic       is_wait,
    output logic       is_raw
);
    always_comb begin
        is_sem  = 1'b0;
        is_wait = 1'b0;
        is_raw  = 1'b0;
        unique case (acc_view)
            VW_RAW:      is_raw  = 1'b1;
            VW_SEM_WAIT: begin is_sem = 1'b1; is_wait = 1'b1; end
            VW_SEM_POLL: is_sem  = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/sem_count_fsm.sv
module sem_count_fsm
    import sem_cell_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_req,
    input  logic             give_req,
    output logic [CNT_W-1:0] count,
    output lvl_e             level
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    lvl_e             lvl_q, lvl_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dec, inc;

    // Permission to move the count follows the level state.
    always_comb begin
        dec = 1'b0;
        inc = 1'b0;
        unique case (lvl_q)
            S_ZERO: begin
                dec = 1'b0;
                inc = give_req;
            end
            S_COUNTING: begin
                dec = take_req;
                inc = give_req;
            end
            S_SATURATED: begin
                dec = take_req;
                inc = give_req && take_req;
            end
            default: ;
        endcase
        cnt_d = cnt_q;
        if (dec) cnt_d = cnt_d - CNT_ONE;
        if (inc) cnt_d = cnt_d + CNT_ONE;
        if (cnt_d == '0)          lvl_d = S_ZERO;
        else if (cnt_d == CNT_TOP) lvl_d = S_SATURATED;
        else                       lvl_d = S_COUNTING;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= S_ZERO;
        else        lvl_q <= lvl_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign level = lvl_q;
endmodule

// File: rtl/sem_waiter_set.sv
module sem_waiter_set #(
    parameter int ID_W = 3,
    localparam int NREQ = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            block_req,
    input  logic [ID_W-1:0] req_id,
    input  logic            give_req,
    output logic            wake_pulse,
    output logic [NREQ-1:0] wake_mask
);
    logic [NREQ-1:0] blk_q, blk_d, new_bit;
    logic            wake_d;

    always_comb begin
        new_bit = '0;
        if (block_req) new_bit[req_id] = 1'b1;
        // A give flushes the old waiters; a stall in the same cycle survives.
        blk_d  = give_req ? new_bit : (blk_q | new_bit);
        wake_d = give_req && (blk_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q      <= '0;
            wake_pulse <= 1'b0;
            wake_mask  <= '0;
        end else begin
            blk_q      <= blk_d;
            wake_pulse <= wake_d;
            wake_mask  <= wake_d ? blk_q : '0;
        end
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ID_W   = 3,
    localparam int NREQ  = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        acc_view,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ID_W-1:0]   req_id,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              stall,
    output logic              wake_pulse,
    output logic [NREQ-1:0]   wake_mask
);
    logic             is_sem, is_wait, is_raw;
    logic             take_req, give_req, block_req;
    logic [CNT_W-1:0] count_q;
    lvl_e             level;
    logic [DATA_W-1:0] rdata_d;
    logic              unused_data;

    assign unused_data = ^wr_data;

    sem_view_decode u_dec (
        .acc_view (acc_view),
        .is_sem   (is_sem),
        .is_wait  (is_wait),
        .is_raw   (is_raw)
    );

    assign take_req  = rd_en && is_sem;
    assign give_req  = wr_en && is_sem;
    assign block_req = take_req && is_wait && (level == S_ZERO);

    sem_count_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_req (take_req),
        .give_req (give_req),
        .count    (count_q),
        .level    (level)
    );

    sem_waiter_set #(.ID_W(ID_W)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_req  (block_req),
        .req_id     (req_id),
        .give_req   (give_req),
        .wake_pulse (wake_pulse),
        .wake_mask  (wake_mask)
    );

    always_comb begin
        rdata_d = '0;
        if (is_sem || is_raw) rdata_d[CNT_W-1:0] = count_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            stall    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rdata_d : '0;
            stall    <= block_req;
        end
    end
endmodule

// File: rtl/sem_cell_checker.sv
module sem_cell_checker #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ID_W   = 3,
    localparam int NREQ  = 1 << ID_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        acc_view,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              stall,
    input logic              wake_pulse,
    input logic [NREQ-1:0]   wake_mask,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;
    logic sem_v;
    assign sem_v = (acc_view == 4'd4) || (acc_view == 4'd5);

    p_take_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sem_v && !wr_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) && rd_valid);

    p_stall_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_view == 4'd4 && cnt == '0) |=> stall && rd_data == '0);

    p_stall_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(rd_en));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sem_v && !rd_en && cnt == TOP) |=> cnt == TOP);

    p_wake_after_give_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(wr_en));

    p_raw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_view == 4'd0 && (rd_en || wr_en)) |=> $stable(cnt));

    p_inert_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sem_v && acc_view != 4'd0) |=> rd_data == '0 && !stall);

    p_wake_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_mask != '0);
endmodule

bind sem_cell sem_cell_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_view   (acc_view),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .stall      (stall),
    .wake_pulse (wake_pulse),
    .wake_mask  (wake_mask),
    .cnt        (count_q)
);

// File: tb/sem_cell_test.sv
module sem_cell_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int ID_W = 3;
    localparam int NREQ = 1 << ID_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        acc_view = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid, stall, wake_pulse;
    logic [NREQ-1:0]   wake_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] s_data;
    logic              s_valid, s_stall, s_wake;
    logic [NREQ-1:0]   s_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_cell uut (
        .clk(clk), .rst_n(rst_n), .acc_view(acc_view), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .req_id(req_id), .rd_data(rd_data), .rd_valid(rd_valid),
        .stall(stall), .wake_pulse(wake_pulse), .wake_mask(wake_mask)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access of one cycle; outputs sampled at the following falling edge.
    task automatic acc(input logic [3:0] v, input logic r, input logic w,
                       input logic [DATA_W-1:0] d, input logic [ID_W-1:0] id);
        @(negedge clk);
        acc_view = v; rd_en = r; wr_en = w; wr_data = d; req_id = id;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        s_data = rd_data; s_valid = rd_valid; s_stall = stall;
        s_wake = wake_pulse; s_mask = wake_mask;
    endtask

    task automatic raw_count(input string req, input logic [DATA_W-1:0] exp);
        acc(4'd0, 1'b1, 1'b0, '0, '0);
        check(req, s_data, exp);
    endtask

    task automatic t_reset;
        check("R1 rd_valid", {31'd0, rd_valid}, 0);
        check("R1 stall", {31'd0, stall}, 0);
        check("R1 wake_pulse", {31'd0, wake_pulse}, 0);
        raw_count("R1 count", 0);
        acc(4'd4, 1'b0, 1'b1, '0, '0);
        check("R1 empty mask (no wake)", {31'd0, s_wake}, 0);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic t_take_give;
        acc(4'd5, 1'b0, 1'b1, 32'hDEAD_BEEF, '0);
        acc(4'd4, 1'b0, 1'b1, 32'h0, '0);
        acc(4'd5, 1'b0, 1'b1, 32'hFFFF_FFFF, '0);
        raw_count("R5 three gives, data ignored", 3);
        acc(4'd5, 1'b1, 1'b0, '0, 3'd1);
        check("R2 take returns old count", s_data, 3);
        check("R2 rd_valid", {31'd0, s_valid}, 1);
        acc(4'd4, 1'b1, 1'b0, '0, 3'd1);
        check("R2 waiting take returns 2", s_data, 2);
        check("R2 no stall when positive", {31'd0, s_stall}, 0);
        raw_count("R2 count lowered", 1);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic t_poll_zero;
        acc(4'd5, 1'b1, 1'b0, '0, 3'd3);
        check("R4 poll at zero data", s_data, 0);
        check("R4 poll at zero no stall", {31'd0, s_stall}, 0);
        acc(4'd5, 1'b0, 1'b1, '0, '0);
        check("R4 not recorded (no wake)", {31'd0, s_wake}, 0);
        raw_count("R4 count after give", 1);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic t_block_wake;
        acc(4'd4, 1'b1, 1'b0, '0, 3'd2);
        check("R3 stall", {31'd0, s_stall}, 1);
        check("R3 data zero", s_data, 0);
        acc(4'd4, 1'b1, 1'b0, '0, 3'd5);
        check("R3 second stall", {31'd0, s_stall}, 1);
        raw_count("R3 count stays zero", 0);
        acc(4'd4, 1'b0, 1'b1, 32'h5, '0);
        check("R6 wake pulse", {31'd0, s_wake}, 1);
        check("R6 wake mask", {24'd0, s_mask}, 32'h24);
        @(negedge clk);
        check("R6 pulse one cycle", {31'd0, wake_pulse}, 0);
        acc(4'd5, 1'b0, 1'b1, '0, '0);
        check("R6 mask cleared", {31'd0, s_wake}, 0);
        raw_count("R6 count 2", 2);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic t_other_views;
        acc(4'd5, 1'b0, 1'b1, '0, '0);
        acc(4'd0, 1'b0, 1'b1, 32'h77, '0);
        raw_count("R7 raw write ignored", 1);
        raw_count("R7 raw read no side effect", 1);
        acc(4'd2, 1'b0, 1'b1, 32'h9, '0);
        acc(4'd1, 1'b0, 1'b1, 32'hFFFF, '0);
        acc(4'd3, 1'b1, 1'b0, '0, '0);
        check("R8 view 3 reads zero", s_data, 0);
        acc(4'd9, 1'b1, 1'b0, '0, '0);
        check("R8 view 9 reads zero", s_data, 0);
        acc(4'd1, 1'b1, 1'b0, '0, '0);
        check("R8 view 1 reads zero", s_data, 0);
        raw_count("R8 count untouched", 1);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic t_same_cycle;
        acc(4'd4, 1'b1, 1'b0, '0, 3'd1);
        acc(4'd4, 1'b1, 1'b1, '0, 3'd6);
        check("R9 stall kept", {31'd0, s_stall}, 1);
        check("R9 wake old mask only", {24'd0, s_mask}, 32'h02);
        raw_count("R9 count after take+give at zero", 1);
        acc(4'd5, 1'b0, 1'b1, '0, '0);
        check("R9 new stall bit woken later", {24'd0, s_mask}, 32'h40);
        acc(4'd5, 1'b1, 1'b1, '0, '0);
        check("R9 take+give returns old count", s_data, 2);
        raw_count("R9 count unchanged", 2);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
        acc(4'd5, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic t_saturate;
        @(negedge clk);
        acc_view = 4'd5; wr_en = 1'b1; wr_data = 32'h1;
        repeat (65538) @(negedge clk);
        wr_en = 1'b0;
        raw_count("R5 saturates at FFFF", 32'hFFFF);
        acc(4'd5, 1'b1, 1'b1, '0, '0);
        check("R9 take+give at top returns FFFF", s_data, 32'hFFFF);
        raw_count("R9 stays at FFFF", 32'hFFFF);
        acc(4'd4, 1'b1, 1'b0, '0, '0);
        check("R2 take at top", s_data, 32'hFFFF);
        raw_count("R2 count FFFE", 32'hFFFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_take_give;
        t_poll_zero;
        t_block_wake;
        t_other_views;
        t_same_cycle;
        t_saturate;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule